// File: doc/BRIEF.md
# Instruction Length and Skip Sequencer

This block sits at the front of a small 16-bit processor. It fetches one instruction word at a time from a single-ported memory and splits it into a 4-bit opcode and two 6-bit operand codes. It works out how many words the whole instruction takes, and it decides what happens next. An ordinary (basic) instruction goes to an external operand decoder and ALU over a valid/ready handshake. A subroutine call is sequenced locally: it pushes the return address and jumps. A reserved encoding is dropped with a one-cycle warning pulse.

A conditional instruction that fails asks, through the ALU completion, for the next instruction to be skipped. The sequencer records that request. On the following instruction it hands nothing over and only steps the program counter over the instruction word and any extra operand words. The addressing of each operand mode and all arithmetic stay outside this block.

The control is a five-state machine:

- FETCH issues a read at PC and always moves to LOAD.
- LOAD sees the returned word. It goes back to FETCH when skipping or on a reserved encoding. It goes to ISSUE for a basic instruction or a call.
- ISSUE holds the handshake until ready, then moves to EXEC.
- EXEC waits for completion. It goes to PUSH for a call and to FETCH otherwise.
- PUSH writes the return address and returns to FETCH.

Top module: `instr_seq`

## Requirements
- R1: After reset PC and SP read 0, no handover or write is pending, and the first memory read is at address 0.
- R2: A handed-over instruction carries the opcode from word bits 3:0, operand code a from bits 9:4 and operand code b from bits 15:10. Opcode 0 means non-basic: a is then a sub-opcode and b the only operand.
- R3: An operand code is "extended" when it lies in 0x10–0x17 or equals 0x1E or 0x1F. The length is 1, plus 1 if b is extended, plus 1 more if the opcode is nonzero and a is extended. The length is reported with each handover.
- R4: The address reported with a handover is the address just after the instruction word.
- R5: After a basic instruction completes, the next read is at its address plus its length.
- R6: When the completion of a basic instruction has the skip input set, the next instruction is not handed over. The read after it is at that instruction's address plus its length, and the instruction after that runs normally.
- R7: Non-basic sub-opcode 1 (call) is handed over with opcode 0 and a = 1. On completion, the return address (call address plus length, modulo 2^ADDR_W) is written at SP−1 (wrapping), SP drops by one, and the next read is at the target returned by the ALU. SP changes only on such a write.
- R8: The skip input is ignored on completion of a call.
- R9: Any other non-basic sub-opcode is never handed over. It raises the illegal output for exactly one cycle, and PC steps by its length.
- R10: A skipped instruction raises no illegal pulse and causes no memory write, whatever its encoding.
- R11: While a handover waits for ready, valid stays high and the fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when set, read otherwise |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Write data (return address) |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| dec_valid | output | 1 | Instruction offered to decoder/ALU |
| dec_ready | input | 1 | Decoder/ALU accepts the offer |
| dec_opcode | output | 4 | Opcode field |
| dec_opa | output | 6 | Operand code a (sub-opcode when non-basic) |
| dec_opb | output | 6 | Operand code b |
| dec_pc | output | ADDR_W | Address of the first word after the instruction word |
| dec_len | output | 2 | Instruction length in words |
| exe_done | input | 1 | One-cycle completion from ALU |
| exe_skip | input | 1 | With completion: skip the next instruction |
| exe_target | input | ADDR_W | With completion of a call: jump target |
| pc | output | ADDR_W | Program counter |
| sp | output | ADDR_W | Stack pointer |
| illegal | output | 1 | One-cycle pulse on a reserved non-basic sub-opcode |

## Verification
The bench builds the block with ADDR_W = 8, so the 256-word program space and stack wrap within a short run. The very first instruction is a call made with SP at 0, so the push lands at address 0xFF. Random jump targets and ongoing pushes later make the program run over words that were stack data. The random program mixes basic, call and reserved encodings with every operand code. Random ready stalls, completion delays and skip requests bring skipped calls and skipped reserved words within reach, as well as back-to-back skips.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int OPD_W  = 6;
    localparam int LEN_W  = 2;
    localparam logic [OPD_W-1:0] SUB_CALL = 6'h01;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_LOAD,
        ST_ISSUE,
        ST_EXEC,
        ST_PUSH
    } seq_state_e;

    typedef struct packed {
        logic [OPD_W-1:0] opb;
        logic [OPD_W-1:0] opa;
        logic [OPC_W-1:0] opc;
    } instr_fields_t;
endpackage

// File: rtl/seq_field_split.sv
module seq_field_split
    import seq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output instr_fields_t     fields,
    output logic              is_basic,
    output logic              is_call
);
    always_comb begin
        fields   = instr_fields_t'(word);
        is_basic = (fields.opc != '0);
        is_call  = !is_basic && (fields.opa == SUB_CALL);
    end
endmodule

// File: rtl/seq_len_calc.sv
module seq_len_calc
    import seq_pkg::*;
(
    input  instr_fields_t     fields,
    input  logic              is_basic,
    output logic [LEN_W-1:0]  len
);
    function automatic logic extended(input logic [OPD_W-1:0] code);
        return (code[5:3] == 3'b010) || (code == 6'h1E) || (code == 6'h1F);
    endfunction

    always_comb begin
        len = LEN_W'(1);
        if (extended(fields.opb))
            len = len + LEN_W'(1);
        if (is_basic && extended(fields.opa))
            len = len + LEN_W'(1);
    end
endmodule

// File: rtl/instr_seq.sv
module instr_seq
    import seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [3:0]        dec_opcode,
    output logic [5:0]        dec_opa,
    output logic [5:0]        dec_opb,
    output logic [ADDR_W-1:0] dec_pc,
    output logic [1:0]        dec_len,
    input  logic              exe_done,
    input  logic              exe_skip,
    input  logic [ADDR_W-1:0] exe_target,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp,
    output logic              illegal
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    seq_state_e    state, state_nx;
    instr_fields_t rd_fields, ir_q;
    logic          rd_basic, rd_call, call_q, skip_q, illegal_q;
    logic [LEN_W-1:0]  rd_len, len_q;
    logic [ADDR_W-1:0] pc_q, sp_q, tgt_q, ret_addr;

    seq_field_split u_split (
        .word     (mem_rdata),
        .fields   (rd_fields),
        .is_basic (rd_basic),
        .is_call  (rd_call)
    );

    seq_len_calc u_len (
        .fields   (rd_fields),
        .is_basic (rd_basic),
        .len      (rd_len)
    );

    assign ret_addr = pc_q + ADDR_W'(len_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = WORD_W'(ret_addr);
        dec_valid = 1'b0;
        unique case (state)
            ST_FETCH: begin
                mem_en   = 1'b1;
                state_nx = ST_LOAD;
            end
            ST_LOAD: begin
                if (skip_q || !(rd_basic || rd_call)) state_nx = ST_FETCH;
                else                                  state_nx = ST_ISSUE;
            end
            ST_ISSUE: begin
                dec_valid = 1'b1;
                if (dec_ready) state_nx = ST_EXEC;
            end
            ST_EXEC: begin
                if (exe_done) state_nx = call_q ? ST_PUSH : ST_FETCH;
            end
            ST_PUSH: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = sp_q - ONE;
                state_nx = ST_FETCH;
            end
            default: state_nx = ST_FETCH;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q      <= '0;
            sp_q      <= '0;
            tgt_q     <= '0;
            skip_q    <= 1'b0;
            call_q    <= 1'b0;
            illegal_q <= 1'b0;
            ir_q      <= '0;
            len_q     <= LEN_W'(1);
        end else begin
            illegal_q <= 1'b0;
            unique case (state)
                ST_LOAD: begin
                    ir_q   <= rd_fields;
                    len_q  <= rd_len;
                    call_q <= rd_call;
                    if (skip_q) begin
                        pc_q   <= pc_q + ADDR_W'(rd_len);
                        skip_q <= 1'b0;
                    end else if (!(rd_basic || rd_call)) begin
                        pc_q      <= pc_q + ADDR_W'(rd_len);
                        illegal_q <= 1'b1;
                    end
                end
                ST_EXEC: begin
                    if (exe_done) begin
                        if (call_q) begin
                            tgt_q <= exe_target;
                        end else begin
                            pc_q   <= ret_addr;
                            skip_q <= exe_skip;
                        end
                    end
                end
                ST_PUSH: begin
                    sp_q <= sp_q - ONE;
                    pc_q <= tgt_q;
                end
                default: ;
            endcase
        end
    end

    assign dec_opcode = ir_q.opc;
    assign dec_opa    = ir_q.opa;
    assign dec_opb    = ir_q.opb;
    assign dec_len    = len_q;
    assign dec_pc     = pc_q + ONE;
    assign pc         = pc_q;
    assign sp         = sp_q;
    assign illegal    = illegal_q;
endmodule

// File: rtl/instr_seq_chk.sv
module instr_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dec_valid,
    input logic              dec_ready,
    input logic [3:0]        dec_opcode,
    input logic [5:0]        dec_opa,
    input logic [5:0]        dec_opb,
    input logic [ADDR_W-1:0] dec_pc,
    input logic [1:0]        dec_len,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] sp,
    input logic              illegal
);
    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !dec_ready |=> dec_valid && $stable({dec_opcode, dec_opa, dec_opb, dec_len})); // R11
    AST_NEXT_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_pc == ADDR_W'(pc + ADDR_W'(1))); // R4
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_len != 2'd0 && (dec_opcode != 4'd0 || dec_len != 2'd3)); // R3
    AST_ONLY_CALL_NONBASIC: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_opcode == 4'd0 |-> dec_opa == 6'd1); // R9
    AST_ILLEGAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal); // R9
    AST_SP_FOLLOWS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && mem_we |=> sp == $past(mem_addr)); // R7
    AST_SP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_en && mem_we) |=> $stable(sp)); // R7
endmodule

bind instr_seq instr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_opcode(dec_opcode),
    .dec_opa(dec_opa), .dec_opb(dec_opb), .dec_pc(dec_pc), .dec_len(dec_len),
    .pc(pc), .sp(sp), .illegal(illegal)
);

// File: tb/instr_seq_tb.sv
module instr_seq_tb;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic dec_valid;
    logic dec_ready = 1'b0;
    logic [3:0] dec_opcode;
    logic [5:0] dec_opa, dec_opb;
    logic [AW-1:0] dec_pc;
    logic [1:0] dec_len;
    logic exe_done = 1'b0;
    logic exe_skip = 1'b0;
    logic [AW-1:0] exe_target = '0;
    logic [AW-1:0] pc, sp;
    logic illegal;

    always #2.5 clk = ~clk;

    instr_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dec_valid(dec_valid),
        .dec_ready(dec_ready), .dec_opcode(dec_opcode), .dec_opa(dec_opa),
        .dec_opb(dec_opb), .dec_pc(dec_pc), .dec_len(dec_len), .exe_done(exe_done),
        .exe_skip(exe_skip), .exe_target(exe_target), .pc(pc), .sp(sp), .illegal(illegal)
    );

    int n_checks = 0, n_errors = 0;
    logic [15:0] mem [0:255];
    int fill_idx = 0;

    // expected state
    logic [AW-1:0] exp_pc = '0, exp_sp = '0, exp_ret = '0, exp_tgt = '0;
    logic exp_skip = 1'b0, pend_issue = 1'b0, pend_push = 1'b0, cur_call = 1'b0;
    logic [1:0] cur_len = 2'd1;
    logic [15:0] cur_word = '0;
    int done_wait = 0, ill_seen = 0, exp_ill = 0, n_fetch = 0, idle = 0;
    int n_skip = 0, n_call = 0, n_resv = 0, n_skip_special = 0;
    logic timeout = 1'b0, finished = 1'b0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic is_ext(input logic [5:0] c);
        return (c >= 6'h10 && c <= 6'h17) || c == 6'h1E || c == 6'h1F;
    endfunction

    function automatic logic [1:0] ref_len(input logic [15:0] w);
        logic [1:0] l = 2'd1;
        if (is_ext(w[15:10])) l++;
        if (w[3:0] != 0 && is_ext(w[9:4])) l++;
        return l;
    endfunction

    function automatic logic [15:0] gen_word();
        logic [3:0] op = 4'($urandom % 16);
        logic [5:0] a = 6'($urandom % 64);
        logic [5:0] b = 6'($urandom % 64);
        if ($urandom % 4 == 0) begin
            op = 4'd0;
            if ($urandom % 2 == 0) a = 6'd1;
        end
        return {b, a, op};
    endfunction

    // memory model and program fill during reset
    always @(posedge clk) begin
        if (!rst_n && fill_idx < 256) begin
            mem[fill_idx[7:0]] <= (fill_idx == 0) ? 16'h7C10 : gen_word(); // call, b=0x1F, length 2
            fill_idx <= fill_idx + 1;
        end else if (rst_n && mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    // stimulus and monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [15:0] w;
            logic [1:0] l;
            idle++;
            if (idle > 200) timeout = 1'b1;
            dec_ready = ($urandom % 3) != 0;
            if (exe_done) exe_done = 1'b0;
            if (done_wait > 0) begin
                done_wait--;
                if (done_wait == 0) begin
                    exe_done   = 1'b1;
                    exe_skip   = ($urandom % 2) == 0;
                    exe_target = AW'($urandom);
                    if (cur_call) begin
                        exp_ret   = exp_pc + AW'(cur_len);
                        exp_tgt   = exe_target;
                        pend_push = 1'b1; // R8: skip input ignored
                    end else begin
                        exp_pc   = exp_pc + AW'(cur_len);
                        exp_skip = exe_skip;
                    end
                end
            end
            if (illegal) ill_seen++;
            if (mem_en && mem_we) begin
                chk(pend_push, "R10 unexpected write", 1, 0);
                chk(mem_addr == AW'(exp_sp - 1), "R7 push address", mem_addr, AW'(exp_sp - 1));
                chk(mem_wdata == 16'(exp_ret), "R7 return address", mem_wdata, exp_ret);
                exp_sp    = exp_sp - 1;
                exp_pc    = exp_tgt;
                pend_push = 1'b0;
                n_call++;
            end
            if (dec_valid && dec_ready) begin
                chk(pend_issue, "R6 handover of skipped or reserved word", 1, 0);
                chk({dec_opb, dec_opa, dec_opcode} == cur_word, "R2 fields",
                    {dec_opb, dec_opa, dec_opcode}, cur_word);
                chk(dec_len == cur_len, "R3 length", dec_len, cur_len);
                chk(dec_pc == AW'(exp_pc + 1), "R4 next word address", dec_pc, AW'(exp_pc + 1));
                pend_issue = 1'b0;
                done_wait  = 1 + int'($urandom % 3);
            end
            if (mem_en && !mem_we) begin
                idle = 0;
                chk(mem_addr == exp_pc, (n_fetch == 0) ? "R1 first read" : "R5 read address",
                    mem_addr, exp_pc);
                chk(pc == exp_pc, "R5 pc port", pc, exp_pc);
                chk(sp == exp_sp, "R7 sp port", sp, exp_sp);
                chk(ill_seen == exp_ill, "R9 illegal pulses", ill_seen, exp_ill);
                chk(!pend_issue && !pend_push && done_wait == 0 && !exe_done,
                    "R6 read while work pending", 1, 0);
                w = mem[mem_addr];
                l = ref_len(w);
                if (exp_skip) begin
                    n_skip++;
                    if (w[3:0] == 0) n_skip_special++; // R10 exposure
                    exp_pc   = exp_pc + AW'(l);
                    exp_skip = 1'b0;
                end else if (w[3:0] != 0 || w[9:4] == 6'd1) begin
                    pend_issue = 1'b1;
                    cur_call   = (w[3:0] == 0);
                    cur_word   = w;
                    cur_len    = l;
                end else begin
                    n_resv++;
                    exp_ill++;
                    exp_pc = exp_pc + AW'(l);
                end
                n_fetch++;
                if (n_fetch >= 3000) finished = 1'b1;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (300) @(posedge clk);
        @(negedge clk);
        chk(pc == 0, "R1 reset pc", pc, 0);
        chk(sp == 0, "R1 reset sp", sp, 0);
        chk(!dec_valid, "R1 reset valid", dec_valid, 0);
        chk(!mem_we, "R1 reset write", mem_we, 0);
        chk(!illegal, "R1 reset illegal", illegal, 0);
        rst_n = 1'b1;
        fork
            wait (finished || timeout);
            begin repeat (150000) @(posedge clk); timeout = 1'b1; end
        join_any
        disable fork;
        chk(!timeout, "R1 watchdog", 1, 0);
        chk(n_skip > 0, "R6 skips exercised", n_skip, 1);
        chk(n_skip_special > 0, "R10 skipped non-basic exercised", n_skip_special, 1);
        chk(n_call > 0, "R7 calls exercised", n_call, 1);
        chk(n_resv > 0, "R9 reserved exercised", n_resv, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule